// File: doc/BRIEF.md
# Keyed Power-Down and Wake Controller

This block sits in an always-on slow-clock domain and decides when the core power rail is switched off and back on. Software programs which external wake pins are watched, with an enable and an active level for each pin. It also chooses a common debounce length from a small fixed menu and selects which of two timer alarm requests, a calendar alarm and a tick alarm, may end a power-down. The block ignores a power-down request unless the request carries an 8-bit password together with a command bit.

Once accepted, the block raises `pwr_down` and holds it high until the first qualified wake event. A wake pin qualifies only after it has stayed at its active level for the whole debounce length without a break. An alarm qualifies as soon as its enable is set. The wake event drops `pwr_down` and records every source active in that cycle in a cause word. After power returns, software reads the cause word once, and the read clears it. A cause word of zero means there was a cold power-on and no wake.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset `pwr_down` is 0. The cause word (offset 0x8), the timing word (offset 0x4) and the pin word (offset 0xC) all read as 0.
- R2: A write to offset 0x0 with bit 0 set and bits 31:24 equal to 0xA5 raises `pwr_down` on the next clock edge.
- R3: A write to offset 0x0 whose bits 31:24 differ from 0xA5, or whose bit 0 is clear, leaves `pwr_down` at 0.
- R4: In the pin word, bit i (15:0) enables pin i and bit 16+i sets its active level (1 = high, 0 = low). An enabled pin at its active level wakes the block. A disabled pin has no effect.
- R5: Bits 26:24 of the timing word select the debounce length. Codes 0 to 5 give 0, 3, 32, 512, 4096 and 32768 cycles, and codes 6 and 7 behave like 5. A pin that becomes active with length L ends the power-down at the (L+1)th clock edge. Any return to the inactive level restarts the count.
- R6: Timing word bit 17 lets `cal_alarm` wake the block on the first edge it is high, and bit 16 does the same for `tick_alarm`. When its bit is clear, an alarm has no effect.
- R7: On a wake event `pwr_down` falls at the same edge. The cause word then shows bit 16+i for each waking pin, bit 5 for `cal_alarm` and bit 4 for `tick_alarm`.
- R8: A read at offset 0x8 returns the cause word and clears it at that edge. When a wake event falls on the same edge, the bits of that event stay set.
- R9: The timing word reads back bits 26:24, 17 and 16 (all other bits read 0), and the pin word reads back all 32 bits. When both words are 0, nothing wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| wake_pin | input | 16 | External wake pins |
| cal_alarm | input | 1 | Calendar alarm wake request |
| tick_alarm | input | 1 | Tick timer alarm wake request |
| pwr_down | output | 1 | High while core power is to be off |

## Verification
The clear-on-read of the cause word and a new wake event can land on the same clock edge. The bench arranges this by leaving a pin cause unread, powering down again, and then raising `cal_alarm` in the same cycle that it reads offset 0x8. That read must return the stale pin cause. A second read must return only bit 5, which shows that the clear removed the old bits and kept the new one.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int NPIN   = 16;
    localparam int DW     = 32;
    localparam int AW     = 4;
    localparam int CNT_W  = 16;
    localparam logic [7:0] PASSKEY = 8'hA5;

    localparam logic [AW-1:0] OFS_CMD  = 4'h0;
    localparam logic [AW-1:0] OFS_TIME = 4'h4;
    localparam logic [AW-1:0] OFS_WHY  = 4'h8;
    localparam logic [AW-1:0] OFS_PINS = 4'hC;

    typedef struct packed {
        logic [2:0] dbc;
        logic       cal_en;
        logic       tick_en;
    } timing_t;

    typedef struct packed {
        logic [NPIN-1:0] level;
        logic [NPIN-1:0] en;
    } pincfg_t;

    typedef struct packed {
        logic [NPIN-1:0] pins;
        logic            cal;
        logic            tick;
    } cause_t;

    function automatic logic [CNT_W-1:0] dbc_len(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(0);
            3'd1:    return CNT_W'(3);
            3'd2:    return CNT_W'(32);
            3'd3:    return CNT_W'(512);
            3'd4:    return CNT_W'(4096);
            default: return CNT_W'(32768);
        endcase
    endfunction

    function automatic logic [DW-1:0] timing_word(input timing_t t);
        return {5'b0, t.dbc, 6'b0, t.cal_en, t.tick_en, 16'b0};
    endfunction

    function automatic logic [DW-1:0] cause_word(input cause_t c);
        return {c.pins, 10'b0, c.cal, c.tick, 4'b0};
    endfunction
endpackage

// File: rtl/pgc_filter.sv
module pgc_filter
    import pgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             level,
    input  logic             pin,
    input  logic [CNT_W-1:0] limit,
    output logic             qual
);
    logic             active;
    logic [CNT_W-1:0] held_q;

    assign active = enable && (pin == level);

    always_ff @(posedge clk) begin
        if (rst || !active)
            held_q <= '0;
        else if (held_q != {CNT_W{1'b1}})
            held_q <= held_q + 1'b1;
    end

    assign qual = active && (held_q >= limit);
endmodule

// File: rtl/pgc_cause.sv
module pgc_cause
    import pgc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  cause_t set,
    output cause_t cause
);
    always_ff @(posedge clk) begin
        if (rst)
            cause <= '0;
        else
            cause <= (clr ? cause_t'('0) : cause) | set;
    end
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
    import pgc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NPIN-1:0] wake_pin,
    input  logic            cal_alarm,
    input  logic            tick_alarm,
    output logic            pwr_down
);
    timing_t         timing_q;
    pincfg_t         pincfg_q;
    logic            down_q;
    logic [NPIN-1:0] pin_ok;
    logic [CNT_W-1:0] limit;
    cause_t          evt;
    cause_t          cause;
    logic            wake;
    logic            cmd_ok;
    logic            cal_arm;
    logic            tick_arm;
    logic [DW-1:0]   why_word;

    assign limit    = dbc_len(timing_q.dbc);
    assign cal_arm  = timing_q.cal_en;
    assign tick_arm = timing_q.tick_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= '0;
            pincfg_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_TIME)
                timing_q <= '{dbc: wdata[26:24], cal_en: wdata[17], tick_en: wdata[16]};
            if (addr == OFS_PINS)
                pincfg_q <= pincfg_t'(wdata);
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pgc_filter u_flt (
            .clk    (clk),
            .rst    (rst),
            .enable (pincfg_q.en[i]),
            .level  (pincfg_q.level[i]),
            .pin    (wake_pin[i]),
            .limit  (limit),
            .qual   (pin_ok[i])
        );
    end

    assign evt.pins = pin_ok & {NPIN{down_q}};
    assign evt.cal  = down_q && cal_alarm && timing_q.cal_en;
    assign evt.tick = down_q && tick_alarm && timing_q.tick_en;
    assign wake     = |evt;
    assign cmd_ok   = wr_en && (addr == OFS_CMD) && (wdata[31:24] == PASSKEY) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst)
            down_q <= 1'b0;
        else if (wake)
            down_q <= 1'b0;
        else if (cmd_ok)
            down_q <= 1'b1;
    end

    pgc_cause u_cause (
        .clk   (clk),
        .rst   (rst),
        .clr   (rd_en && (addr == OFS_WHY)),
        .set   (evt),
        .cause (cause)
    );

    assign why_word = cause_word(cause);

    always_comb begin
        case (addr)
            OFS_TIME: rdata = timing_word(timing_q);
            OFS_WHY:  rdata = why_word;
            OFS_PINS: rdata = pincfg_q;
            default:  rdata = '0;
        endcase
    end

    assign pwr_down = down_q;
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
    import pgc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          cal_alarm,
    input logic          tick_alarm,
    input logic          cal_arm,
    input logic          tick_arm,
    input logic [DW-1:0] why_word,
    input logic          pwr_down
);
    logic good_cmd;
    assign good_cmd = wr_en && addr == OFS_CMD && wdata[31:24] == PASSKEY && wdata[0];

    p_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && good_cmd) |=> pwr_down);

    p_no_bad_key_r3: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && !good_cmd) |=> !pwr_down);

    p_alarm_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && ((cal_alarm && cal_arm) || (tick_alarm && tick_arm))) |=> !pwr_down);

    p_cause_on_wake_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |-> (why_word != '0));

    p_cause_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && !(rd_en && addr == OFS_WHY)) |=> $stable(why_word));
endmodule

bind pwr_gate_ctrl pgc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .cal_alarm  (cal_alarm),
    .tick_alarm (tick_alarm),
    .cal_arm    (cal_arm),
    .tick_arm   (tick_arm),
    .why_word   (why_word),
    .pwr_down   (pwr_down)
);

// File: tb/tb_pwr_gate_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] wake_pin = '0;
    logic        cal_alarm = 1'b0;
    logic        tick_alarm = 1'b0;
    logic        pwr_down;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwr_gate_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wake_pin(wake_pin),
        .cal_alarm(cal_alarm), .tick_alarm(tick_alarm), .pwr_down(pwr_down)
    );

    function automatic int len_of(input int code);
        case (code)
            0: return 0;
            1: return 3;
            2: return 32;
            3: return 512;
            4: return 4096;
            default: return 32768;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [15:0] polv, env;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pwr_down", {31'b0, pwr_down}, 32'd0);
        rd(4'h8, v); check("R1 cause", v, 0);
        rd(4'h4, v); check("R1 timing", v, 0);
        rd(4'hC, v); check("R1 pins", v, 0);

        // R3 bad key / missing command bit
        wr(4'h0, 32'h5A00_0001); check("R3 bad key", {31'b0, pwr_down}, 0);
        wr(4'h0, 32'hA500_0000); check("R3 no bit0", {31'b0, pwr_down}, 0);

        // R9 readback
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); check("R9 timing readback", v, 32'h0703_0000);
        wr(4'hC, 32'h1234_ABCD); rd(4'hC, v); check("R9 pins readback", v, 32'h1234_ABCD);
        wr(4'h4, 0); wr(4'hC, 0);

        // R2 accept, R9 zero config never wakes
        wr(4'h0, 32'hA500_0001); check("R2 accepted", {31'b0, pwr_down}, 1);
        @(negedge clk); cal_alarm = 1; tick_alarm = 1; wake_pin = 16'hFFFF;
        repeat (5) @(negedge clk);
        check("R9 disabled stays down", {31'b0, pwr_down}, 1);
        wake_pin = 16'h0;
        repeat (5) @(negedge clk);
        check("R9 disabled stays down low", {31'b0, pwr_down}, 1);

        // R6 tick alarm enabled (cal disabled) wakes next edge, R7 cause
        tick_alarm = 0;
        wr(4'h4, 32'h0001_0000);          // tick enabled; cal_alarm still high, ignored
        check("R6 cal ignored", {31'b0, pwr_down}, 1);
        @(negedge clk); tick_alarm = 1;
        @(negedge clk); check("R6 tick wake", {31'b0, pwr_down}, 0);
        cal_alarm = 0; tick_alarm = 0;
        rd(4'h8, v); check("R7 tick cause", v, 32'h10);
        rd(4'h8, v); check("R8 cleared", v, 0);

        // R4 disabled pin ignored, R5 interrupted count (code 1 -> 3)
        wr(4'hC, 32'h0004_0004);          // pin2 enabled active high
        wr(4'h4, 32'h0100_0000);
        wr(4'h0, 32'hA500_0001);
        @(negedge clk); wake_pin = 16'h0001; // pin0 disabled
        repeat (6) @(negedge clk);
        check("R4 disabled pin", {31'b0, pwr_down}, 1);
        wake_pin = 16'h0004;
        repeat (2) @(negedge clk);
        wake_pin = 16'h0000;
        @(negedge clk); wake_pin = 16'h0004;
        repeat (3) @(negedge clk);
        check("R5 restart held", {31'b0, pwr_down}, 1);
        @(negedge clk);
        check("R5 restart wake", {31'b0, pwr_down}, 0);
        wake_pin = 0;

        // R8 same-edge read and wake: leave pin2 cause unread
        wr(4'h4, 32'h0002_0000);          // cal enabled
        wr(4'h0, 32'hA500_0001);
        @(negedge clk);
        rd_en = 1; addr = 4'h8; cal_alarm = 1;
        #1 v = rdata;
        @(negedge clk); rd_en = 0; cal_alarm = 0;
        check("R8 stale read", v, 32'h0004_0000);
        check("R7 cal wake", {31'b0, pwr_down}, 0);
        rd(4'h8, v); check("R8 new kept", v, 32'h20);

        // R5 longest code (7 acts as 32768), active-low pin
        wake_pin = 16'hFFFF;
        wr(4'hC, 32'h0000_8000);          // pin15 enabled, active low
        wr(4'h4, 32'h0700_0000);
        wr(4'h0, 32'hA500_0001);
        @(negedge clk); wake_pin[15] = 1'b0;
        repeat (32768) @(negedge clk);
        check("R5 max held", {31'b0, pwr_down}, 1);
        @(negedge clk);
        check("R5 max wake", {31'b0, pwr_down}, 0);
        rd(4'h8, v); check("R4 low pin cause", v, 32'h8000_0000);

        // random pins, levels, codes
        for (int n = 0; n < 16; n++) begin
            int idx = $urandom % 16;
            int code = $urandom % 3;
            int L = len_of(code);
            polv = 16'($urandom);
            env  = 16'($urandom) | (16'd1 << idx);
            wake_pin = ~polv;
            wr(4'hC, {polv, env});
            wr(4'h4, 32'(code) << 24);
            wr(4'h0, 32'hA500_0001);
            check("R2 random down", {31'b0, pwr_down}, 1);
            @(negedge clk); wake_pin[idx] = polv[idx];
            if (L > 0) begin
                repeat (L) @(negedge clk);
                check("R5 random held", {31'b0, pwr_down}, 1);
            end
            @(negedge clk);
            check("R4 random wake", {31'b0, pwr_down}, 0);
            rd(4'h8, v); check("R7 random cause", v, (32'd1 << idx) << 16);
            wake_pin = ~polv;
        end

        finish_run();
    end
endmodule